// File: doc/BRIEF.md
# CAN Error-State Flag Register

This block sits beside a CAN controller's error counters and turns the raw transmit and receive counter values into two 2-bit bus status classes: ok, warning, passive and bus-off. It keeps a snapshot of both classes in a small status register. When either computed class moves away from the snapshot, it raises a status-change flag. While that flag is pending the snapshot is frozen, so software reads a class pair that matches the event that raised the interrupt. A second flag records bus activity that is seen while the controller sleeps with wake-up enabled.

Software reads everything through one read word. It clears the flags by writing ones through a 2-bit write-one-to-clear port. While the controller is in initialization mode (request and acknowledge both high), both flags are held cleared and clears have no effect. The snapshot is neither reset nor updated in that mode. When initialization ends, any class difference that built up raises the change flag. Each flag drives its own interrupt output through its own enable.

Read word layout:

| Bits | Content |
|------|---------|
| 0 | Change flag |
| 1 | Wake flag |
| [3:2] | Transmit class |
| [5:4] | Receive class |
| Upper bits | Zero |

Class codes: 00 is ok, 01 is warning, 10 is passive, 11 is bus-off.

Top module: `can_errstate_flags`

## Requirements
- R1: The transmit class is 00 for a count of 0..96, 01 for 97..127, 10 for 128..255 and 11 above 255. It is read at rd_data[3:2].
- R2: The receive class is 00 for 0..96, 01 for 97..127 and 10 for 128..255. It is forced to 11 whenever the transmit count is above 255. It is read at rd_data[5:4].
- R3: When neither the change flag nor initialization mode is active and the computed class pair differs from the snapshot, the next clock edge sets the change flag (rd_data[0]) and loads the new pair into the snapshot.
- R4: While the change flag is set and no clear is written, the snapshot in rd_data[5:2] does not change, whatever the counters do.
- R5: Writing wr_data[0]=1 clears the change flag when the computed pair equals the snapshot. If the pair differs in the same cycle, the set wins: the flag stays set and the snapshot takes the new pair.
- R6: The wake flag (rd_data[1]) sets when bus_act, sleep_mode and wake_en are all high in the same cycle, and not otherwise. A set in the same cycle as a clear wins.
- R7: Writing 0 to a flag bit leaves that flag unchanged. Writing wr_data[1]=1 clears the wake flag.
- R8: With init_req and init_ack both high, both flags read 0, and activity and clears have no effect. The snapshot keeps its value and ignores the counters. Init_req alone has no effect.
- R9: chg_irq equals the change flag ANDed with chg_ie, and wake_irq equals the wake flag ANDed with wake_ie.
- R10: After reset, rd_data is all zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_cnt | input | TX_W (9) | Transmit error counter value |
| rx_cnt | input | RX_W (8) | Receive error counter value |
| bus_act | input | 1 | Bus activity strobe |
| sleep_mode | input | 1 | Controller is asleep |
| wake_en | input | 1 | Wake-up detection enabled |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 2 | Write-one-to-clear mask: bit 0 clears the change flag, bit 1 clears the wake flag |
| rd_data | output | DATA_W (8) | Read word laid out as in the table above |
| chg_ie | input | 1 | Change interrupt enable |
| wake_ie | input | 1 | Wake interrupt enable |
| chg_irq | output | 1 | Change interrupt |
| wake_irq | output | 1 | Wake interrupt |

## Verification
A wrong snapshot or flag state shows on rd_data one clock edge after the stimulus that exposes it, because every field is read straight from a register. A snapshot that fails to block shows as class bits moving while bit 0 stays high. A lost set-wins decision shows as bit 0 dropping in the same cycle that the counters crossed a threshold. An initialization hold that leaks shows as a flag surviving the first cycle of init, or as class bits tracking the counters during init.

// File: rtl/can_errstate_pkg.sv
package can_errstate_pkg;

   typedef enum logic [1:0] {
      ES_OK      = 2'b00,
      ES_WARN    = 2'b01,
      ES_PASSIVE = 2'b10,
      ES_BUSOFF  = 2'b11
   } es_class_t;

   typedef struct packed {
      es_class_t rx;
      es_class_t tx;
   } es_snap_t;

endpackage

// File: rtl/errstate_classify.sv
module errstate_classify
   import can_errstate_pkg::*;
#(
   parameter int unsigned CNT_W       = 9,
   parameter int unsigned WARN_LVL    = 96,
   parameter int unsigned PASSIVE_LVL = 127,
   parameter int unsigned BUSOFF_LVL  = 255
) (
   input  logic [CNT_W-1:0] cnt,
   output es_class_t        cls
);

   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W > 16) begin : g_bad_width
         $error("errstate_classify: CNT_W must not exceed 16");
      end
      if (!(WARN_LVL < PASSIVE_LVL && PASSIVE_LVL < BUSOFF_LVL)) begin : g_bad_lvl
         $error("errstate_classify: thresholds must rise strictly");
      end
   endgenerate

   logic [31:0] cnt_ext;
   assign cnt_ext = 32'(cnt);

   generate
      if (CNT_MAX > BUSOFF_LVL) begin : g_with_busoff
         always_comb begin
            if (cnt_ext > BUSOFF_LVL)       cls = ES_BUSOFF;
            else if (cnt_ext > PASSIVE_LVL) cls = ES_PASSIVE;
            else if (cnt_ext > WARN_LVL)    cls = ES_WARN;
            else                            cls = ES_OK;
         end
      end else begin : g_no_busoff
         always_comb begin
            if (cnt_ext > PASSIVE_LVL)      cls = ES_PASSIVE;
            else if (cnt_ext > WARN_LVL)    cls = ES_WARN;
            else                            cls = ES_OK;
         end
      end
   endgenerate

endmodule

// File: rtl/errstate_snapshot.sv
module errstate_snapshot
   import can_errstate_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hold_init,
   input  es_snap_t cls_now,
   input  logic     clr_req,
   output es_snap_t snap,
   output logic     pend
);

   logic diff;
   assign diff = (cls_now != snap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap <= '{rx: ES_OK, tx: ES_OK};
         pend <= 1'b0;
      end else if (hold_init) begin
         pend <= 1'b0;
      end else if (!pend || clr_req) begin
         pend <= diff;
         if (diff) snap <= cls_now;
      end
   end

   AST_SET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_init && !pend && diff) |=> (pend && snap == $past(cls_now))); // R3

   AST_BLOCKING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr_req && !hold_init) |=> (pend && $stable(snap))); // R4

   AST_CLEAR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && clr_req && !hold_init && diff) |=> pend); // R5

   AST_INIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_init |=> (!pend && $stable(snap))); // R8

endmodule

// File: rtl/errstate_w1c_flag.sv
module errstate_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_init,
   input  logic set_ev,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (hold_init) flag <= 1'b0;
      else if (set_ev)    flag <= 1'b1;
      else if (clr_req)   flag <= 1'b0;
   end

   AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && !hold_init) |=> flag); // R6

   AST_WRITE_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_ev && !clr_req && !hold_init) |=> $stable(flag)); // R7

endmodule

// File: rtl/can_errstate_flags.sv
module can_errstate_flags
   import can_errstate_pkg::*;
#(
   parameter int unsigned TX_W        = 9,
   parameter int unsigned RX_W        = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WARN_LVL    = 96,
   parameter int unsigned PASSIVE_LVL = 127,
   parameter int unsigned BUSOFF_LVL  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TX_W-1:0]   tx_cnt,
   input  logic [RX_W-1:0]   rx_cnt,
   input  logic              bus_act,
   input  logic              sleep_mode,
   input  logic              wake_en,
   input  logic              init_req,
   input  logic              init_ack,
   input  logic              wr_en,
   input  logic [1:0]        wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              chg_ie,
   input  logic              wake_ie,
   output logic              chg_irq,
   output logic              wake_irq
);

   localparam int unsigned CHG_BIT  = 0;
   localparam int unsigned WAKE_BIT = 1;
   localparam int unsigned TX_LSB   = 2;
   localparam int unsigned RX_LSB   = 4;
   localparam int unsigned TX_MAX   = (1 << TX_W) - 1;

   generate
      if (DATA_W < RX_LSB + 2) begin : g_bad_data
         $error("can_errstate_flags: DATA_W too small for the read layout");
      end
      if (TX_MAX <= BUSOFF_LVL) begin : g_bad_tx
         $error("can_errstate_flags: TX_W cannot express a bus-off count");
      end
      if (RX_W > TX_W) begin : g_bad_rx
         $error("can_errstate_flags: RX_W wider than TX_W is not supported");
      end
   endgenerate

   logic      in_init;
   es_class_t tx_cls;
   es_class_t rx_base;
   es_snap_t  cls_now;
   es_snap_t  snap;
   logic      chg_flag;
   logic      wake_flag;
   logic      clr_chg;
   logic      clr_wake;

   assign in_init  = init_req & init_ack;
   assign clr_chg  = wr_en & wr_data[0];
   assign clr_wake = wr_en & wr_data[1];

   errstate_classify #(
      .CNT_W(TX_W), .WARN_LVL(WARN_LVL),
      .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
   ) i_tx_cls (
      .cnt(tx_cnt),
      .cls(tx_cls)
   );

   errstate_classify #(
      .CNT_W(RX_W), .WARN_LVL(WARN_LVL),
      .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
   ) i_rx_cls (
      .cnt(rx_cnt),
      .cls(rx_base)
   );

   always_comb begin
      cls_now.tx = tx_cls;
      cls_now.rx = (tx_cls == ES_BUSOFF) ? ES_BUSOFF : rx_base;
   end

   errstate_snapshot i_snap (
      .clk(clk),
      .rst_n(rst_n),
      .hold_init(in_init),
      .cls_now(cls_now),
      .clr_req(clr_chg),
      .snap(snap),
      .pend(chg_flag)
   );

   errstate_w1c_flag i_wake (
      .clk(clk),
      .rst_n(rst_n),
      .hold_init(in_init),
      .set_ev(bus_act & sleep_mode & wake_en),
      .clr_req(clr_wake),
      .flag(wake_flag)
   );

   always_comb begin
      rd_data                 = '0;
      rd_data[CHG_BIT]        = chg_flag;
      rd_data[WAKE_BIT]       = wake_flag;
      rd_data[TX_LSB +: 2]    = snap.tx;
      rd_data[RX_LSB +: 2]    = snap.rx;
   end

   assign chg_irq  = chg_flag & chg_ie;
   assign wake_irq = wake_flag & wake_ie;

endmodule

// File: tb/test_can_errstate_flags.sv
module test_can_errstate_flags;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] tx_cnt = '0;
   logic [7:0] rx_cnt = '0;
   logic       bus_act = 1'b0, sleep_mode = 1'b0, wake_en = 1'b0;
   logic       init_req = 1'b0, init_ack = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_data = '0;
   logic       chg_ie = 1'b1, wake_ie = 1'b1;
   logic [7:0] rd_data;
   logic       chg_irq, wake_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] rd;
      logic       c;
      logic       w;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   can_errstate_flags i_can_errstate_flags (
      .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
      .bus_act(bus_act), .sleep_mode(sleep_mode), .wake_en(wake_en),
      .init_req(init_req), .init_ack(init_ack), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .chg_ie(chg_ie),
      .wake_ie(wake_ie), .chg_irq(chg_irq), .wake_irq(wake_irq)
   );

   task automatic compare(exp_t e);
      checks++;
      if (rd_data !== e.rd || chg_irq !== e.c || wake_irq !== e.w) begin
         failures++;
         $display("FAIL %s: rd=%h c=%b w=%b expected rd=%h c=%b w=%b",
                  e.tag, rd_data, chg_irq, wake_irq, e.rd, e.c, e.w);
      end
   endtask

   // driver: the inputs already hold this cycle's stimulus; push the result due after the next edge
   task automatic step(logic [7:0] rd, logic c, logic w, string tag);
      exp_t e;
      e.rd = rd; e.c = c; e.w = w; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = 2'b00;
      bus_act = 1'b0;
   endtask

   // monitor
   always begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) compare(q.pop_front());
   end

   task automatic clr(logic [1:0] m);
      wr_en = 1'b1;
      wr_data = m;
   endtask

   initial begin
      exp_t e0;
      repeat (3) @(negedge clk);
      e0.rd = 8'h00; e0.c = 1'b0; e0.w = 1'b0; e0.tag = "R10 reset state";
      compare(e0);
      rst_n = 1'b1;
      @(negedge clk);

      tx_cnt = 9'd100;                step(8'h05, 1, 0, "R1 R3 R9 tx warning sets flag");
      tx_cnt = 9'd200;                step(8'h05, 1, 0, "R4 snapshot blocked");
      clr(2'b00);                     step(8'h05, 1, 0, "R7 write zero keeps flag");
      clr(2'b01);                     step(8'h09, 1, 0, "R5 clear with pending change, set wins");
      clr(2'b01);                     step(8'h08, 0, 0, "R5 clear without difference");
      rx_cnt = 8'd97;                 step(8'h19, 1, 0, "R2 rx warning");
      clr(2'b01);                     step(8'h18, 0, 0, "R5 clear");
      tx_cnt = 9'd256;                step(8'h3D, 1, 0, "R1 R2 bus-off forces both classes");
      clr(2'b01);                     step(8'h3C, 0, 0, "R5 clear");
      tx_cnt = 9'd96; rx_cnt = 8'd96; step(8'h01, 1, 0, "R1 R2 boundary 96 is ok");
      clr(2'b01);                     step(8'h00, 0, 0, "R5 clear");
      tx_cnt = 9'd127; rx_cnt = 8'd127; step(8'h15, 1, 0, "R1 R2 boundary 127 is warning");
      clr(2'b01);                     step(8'h14, 0, 0, "R5 clear");
      tx_cnt = 9'd128; rx_cnt = 8'd255; step(8'h29, 1, 0, "R1 R2 passive");
      clr(2'b01);                     step(8'h28, 0, 0, "R5 clear");

      bus_act = 1; sleep_mode = 1; wake_en = 0; step(8'h28, 0, 0, "R6 no wake when disabled");
      bus_act = 1; wake_en = 1;       step(8'h2A, 0, 1, "R6 R9 wake sets");
      bus_act = 1; sleep_mode = 0;    step(8'h2A, 0, 1, "R6 wake held");
      clr(2'b10);                     step(8'h28, 0, 0, "R7 wake cleared by one");
      bus_act = 1;                    step(8'h28, 0, 0, "R6 no wake while awake");
      bus_act = 1; sleep_mode = 1; clr(2'b10); step(8'h2A, 0, 1, "R6 set beats clear");

      init_req = 1;                   step(8'h2A, 0, 1, "R8 request alone no hold");
      init_ack = 1;                   step(8'h28, 0, 0, "R8 init clears flags keeps status");
      tx_cnt = 9'd0;                  step(8'h28, 0, 0, "R8 status frozen in init");
      bus_act = 1;                    step(8'h28, 0, 0, "R8 activity ignored in init");
      init_req = 0; init_ack = 0;     step(8'h21, 1, 0, "R8 R3 exit init raises change");
      chg_ie = 0;                     step(8'h21, 0, 0, "R9 change irq masked");
      wake_ie = 0; bus_act = 1;       step(8'h23, 0, 0, "R9 wake irq masked");

      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule